// File: doc/BRIEF.md
# Supervisor-Call Priority Gate

This block sits beside a small exception controller and rules on each supervisor-call request. From the priority of the exception now running, a global mask bit and a base-priority threshold it derives the current execution priority. A call is then either taken or turned into a hard fault. A call blocked by priority is never left pending. If a hard fault is already running when the request arrives, the block reports a lockup instead of raising a second fault.

When it escalates, the block also records which security state will handle the hard fault. The choice comes from a routing control bit. The secure state is the default, and the non-secure state is chosen when the routing bit is set. All three verdicts are registered pulses that appear in the cycle after the request strobe.

Top module: `exc_prio_gate`

## Requirements
- R1: After reset, take_call_o, escalate_o and lockup_o are 0, and fault_ns_o is 0 (secure).
- R2: When mask_all_i is 1 and no hard fault is active, every request escalates, whatever svc_prio_i is (0x00 included).
- R3: A call is taken only if svc_prio_i is numerically lower than the execution priority. An equal value escalates.
- R4: In thread mode (thread_mode_i=1) with mask_all_i=0 and base_thr_i=0x00, the execution priority is 256, so a call at any priority (0xFF included) is taken.
- R5: A nonzero base_thr_i caps the execution priority. A call whose priority is lower than the threshold is taken, and one at or above it escalates (threshold 0x02: a call at 0x01 is taken, a call at 0x02 escalates).
- R6: base_thr_i = 0x00 applies no capping.
- R7: In handler mode (thread_mode_i=0) the execution priority is the lowest of active_prio_i, a nonzero base_thr_i, and 0x00 when mask_all_i is set.
- R8: Each verdict is a one-cycle pulse in the cycle after a request strobe. At most one of take_call_o, escalate_o and lockup_o is high, and none is high in the cycle after a cycle with no request.
- R9: On escalation, fault_ns_o takes the value of route_ns_i sampled with the request: 0 means secure and 1 means non-secure. At other times it holds its value.
- R10: A request made while fault_active_i is 1 gives lockup_o and never escalate_o or take_call_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Supervisor-call request strobe |
| thread_mode_i | input | 1 | 1 = no exception active |
| active_prio_i | input | 8 | Priority of the running exception (handler mode) |
| mask_all_i | input | 1 | Global mask bit |
| base_thr_i | input | 8 | Base-priority threshold, 0 = off |
| svc_prio_i | input | 8 | Configured supervisor-call priority |
| fault_active_i | input | 1 | A hard fault is running |
| route_ns_i | input | 1 | Hard-fault routing: 1 = non-secure |
| take_call_o | output | 1 | Call entry pulse |
| escalate_o | output | 1 | Hard-fault escalation pulse |
| lockup_o | output | 1 | Lockup pulse |
| fault_ns_o | output | 1 | Target state of the last escalated fault |

## Verification
Directed cases put the call priority at the threshold, one step above it and one step below it. This separates a strict compare from a non-strict one, and a capping threshold from an ignored one. With the global mask, the call priority is set to 0x00 to show that masking is total. In thread mode it is set to 0xFF to show that the idle level is above every configurable value. Random sweeps over small priority ranges hit equality often and mix handler mode, both mask sources, the fault-active input and both routing values. A behavioural model checks every output on every clock, including cycles with no request.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;
  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,
    DEC_TAKE = 2'd1,
    DEC_ESC  = 2'd2,
    DEC_LOCK = 2'd3
  } svc_dec_e;
endpackage

// File: rtl/exec_prio_calc.sv
module exec_prio_calc #(
  parameter int PRIO_W      = 8,
  parameter bit USE_BASETHR = 1'b1
) (
  input  logic              thread_mode_i,
  input  logic [PRIO_W-1:0] active_prio_i,
  input  logic              mask_all_i,
  input  logic [PRIO_W-1:0] base_thr_i,
  output logic [PRIO_W:0]   exec_prio_o
);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  logic [PRIO_W:0] run_prio;
  logic [PRIO_W:0] capped_prio;

  assign run_prio = thread_mode_i ? IDLE_PRIO : {1'b0, active_prio_i};

  generate
    if (USE_BASETHR) begin : g_thr
      logic [PRIO_W:0] thr_ext;
      assign thr_ext = {1'b0, base_thr_i};
      // zero threshold disables capping
      assign capped_prio = (base_thr_i != '0 && thr_ext < run_prio) ? thr_ext : run_prio;
    end else begin : g_nothr
      logic unused_thr;
      assign unused_thr  = ^base_thr_i;
      assign capped_prio = run_prio;
    end
  endgenerate

  assign exec_prio_o = mask_all_i ? '0 : capped_prio;
endmodule

// File: rtl/svc_decide.sv
module svc_decide
  import exc_prio_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              req_i,
  input  logic              fault_active_i,
  input  logic [PRIO_W-1:0] svc_prio_i,
  input  logic [PRIO_W:0]   exec_prio_i,
  output svc_dec_e          dec_o
);
  always_comb begin
    dec_o = DEC_NONE;
    if (req_i) begin
      if (fault_active_i)                          dec_o = DEC_LOCK;
      else if ({1'b0, svc_prio_i} < exec_prio_i)   dec_o = DEC_TAKE;
      else                                         dec_o = DEC_ESC;
    end
  end
endmodule

// File: rtl/exc_prio_gate.sv
module exc_prio_gate
  import exc_prio_pkg::*;
#(
  parameter int PRIO_W      = 8,
  parameter bit USE_BASETHR = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              thread_mode_i,
  input  logic [PRIO_W-1:0] active_prio_i,
  input  logic              mask_all_i,
  input  logic [PRIO_W-1:0] base_thr_i,
  input  logic [PRIO_W-1:0] svc_prio_i,
  input  logic              fault_active_i,
  input  logic              route_ns_i,
  output logic              take_call_o,
  output logic              escalate_o,
  output logic              lockup_o,
  output logic              fault_ns_o
);
  logic [PRIO_W:0] exec_prio;
  svc_dec_e        dec;

  exec_prio_calc #(.PRIO_W(PRIO_W), .USE_BASETHR(USE_BASETHR)) i_calc (
    .thread_mode_i (thread_mode_i),
    .active_prio_i (active_prio_i),
    .mask_all_i    (mask_all_i),
    .base_thr_i    (base_thr_i),
    .exec_prio_o   (exec_prio)
  );

  svc_decide #(.PRIO_W(PRIO_W)) i_dec (
    .req_i          (req_i),
    .fault_active_i (fault_active_i),
    .svc_prio_i     (svc_prio_i),
    .exec_prio_i    (exec_prio),
    .dec_o          (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_call_o <= 1'b0;
      escalate_o  <= 1'b0;
      lockup_o    <= 1'b0;
      fault_ns_o  <= 1'b0;
    end else begin
      take_call_o <= (dec == DEC_TAKE);
      escalate_o  <= (dec == DEC_ESC);
      lockup_o    <= (dec == DEC_LOCK);
      if (dec == DEC_ESC) fault_ns_o <= route_ns_i;
    end
  end
endmodule

// File: rtl/exc_prio_gate_chk.sv
module exc_prio_gate_chk #(
  parameter int PRIO_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              thread_mode_i,
  input logic              mask_all_i,
  input logic [PRIO_W-1:0] base_thr_i,
  input logic [PRIO_W-1:0] svc_prio_i,
  input logic              fault_active_i,
  input logic              route_ns_i,
  input logic              take_call_o,
  input logic              escalate_o,
  input logic              lockup_o,
  input logic              fault_ns_o
);
  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({take_call_o, escalate_o, lockup_o}));

  p_noreq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !(take_call_o || escalate_o || lockup_o));

  p_mask_esc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mask_all_i && !fault_active_i |=> escalate_o);

  p_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && fault_active_i |=> lockup_o);

  p_idle_take_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && thread_mode_i && !mask_all_i && base_thr_i == '0 && !fault_active_i |=> take_call_o);

  p_equal_esc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && thread_mode_i && !mask_all_i && !fault_active_i &&
    base_thr_i != '0 && svc_prio_i == base_thr_i |=> escalate_o);

  p_route_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !fault_active_i |=> (escalate_o ? fault_ns_o == $past(route_ns_i) : 1'b1));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(fault_ns_o));
endmodule

bind exc_prio_gate exc_prio_gate_chk #(.PRIO_W(PRIO_W)) i_chk (.*);

// File: tb/test_exc_prio_gate.sv
module test_exc_prio_gate;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, thread_mode_i = 1'b1, mask_all_i = 1'b0;
  logic       fault_active_i = 1'b0, route_ns_i = 1'b0;
  logic [7:0] active_prio_i = '0, base_thr_i = '0, svc_prio_i = '0;
  logic       take_call_o, escalate_o, lockup_o, fault_ns_o;

  int checks = 0, fails = 0, cyc = 0;
  logic e_take = 0, e_esc = 0, e_lock = 0, e_ns = 0;

  always #2 clk_i = ~clk_i;

  exc_prio_gate i_exc_prio_gate (.*);

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: integers, 256 = idle level
  task automatic model();
    int ep;
    ep = thread_mode_i ? 256 : int'(active_prio_i);
    if (base_thr_i != 0 && int'(base_thr_i) < ep) ep = int'(base_thr_i);
    if (mask_all_i) ep = 0;
    e_take = 0; e_esc = 0; e_lock = 0;
    if (req_i) begin
      if (fault_active_i) e_lock = 1;
      else if (int'(svc_prio_i) < ep) e_take = 1;
      else begin e_esc = 1; e_ns = route_ns_i; end
    end
  endtask

  task automatic step(string tag);
    @(posedge clk_i);
    model();
    cyc++;
    @(negedge clk_i);
    chk({tag, " take"}, take_call_o, e_take);
    chk({tag, " esc"},  escalate_o,  e_esc);
    chk({tag, " lock"}, lockup_o,    e_lock);
    chk({tag, " ns"},   fault_ns_o,  e_ns);
  endtask

  task automatic req(string tag, logic th, logic [7:0] ap, logic m, logic [7:0] bt,
                     logic [7:0] sp, logic fa, logic rt);
    thread_mode_i = th; active_prio_i = ap; mask_all_i = m; base_thr_i = bt;
    svc_prio_i = sp; fault_active_i = fa; route_ns_i = rt; req_i = 1'b1;
    step(tag);
    req_i = 1'b0;
    step({tag, " idle R8"});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    chk("R1 take", take_call_o, 1'b0);
    chk("R1 esc",  escalate_o,  1'b0);
    chk("R1 lock", lockup_o,    1'b0);
    chk("R1 ns",   fault_ns_o,  1'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    step("R1 post-reset");

    req("R4 idle 0xFF",        1, 8'h00, 0, 8'h00, 8'hFF, 0, 0);
    req("R2 mask 0x00",        1, 8'h00, 1, 8'h00, 8'h00, 0, 0);
    req("R9 secure route",     1, 8'h00, 1, 8'h00, 8'h05, 0, 0);
    req("R9 ns route",         1, 8'h00, 1, 8'h00, 8'h05, 0, 1);
    req("R5 below thr",        1, 8'h00, 0, 8'h02, 8'h01, 0, 0);
    req("R5 R3 equal thr",     1, 8'h00, 0, 8'h02, 8'h02, 0, 1);
    req("R5 above thr",        1, 8'h00, 0, 8'h02, 8'h03, 0, 0);
    req("R6 thr zero",         0, 8'h80, 0, 8'h00, 8'h7F, 0, 0);
    req("R7 R3 equal active",  0, 8'h40, 0, 8'h00, 8'h40, 0, 1);
    req("R7 thr under active", 0, 8'h40, 0, 8'h20, 8'h30, 0, 0);
    req("R7 active under thr", 0, 8'h10, 0, 8'h20, 8'h12, 0, 1);
    req("R7 mask in handler",  0, 8'hF0, 1, 8'h00, 8'h00, 0, 0);
    req("R10 lockup",          1, 8'h00, 0, 8'h00, 8'h00, 1, 1);
    req("R10 lockup masked",   1, 8'h00, 1, 8'h00, 8'h00, 1, 0);

    for (int i = 0; i < 3000; i++) begin
      thread_mode_i  = 1'($urandom_range(0, 1));
      active_prio_i  = 8'($urandom_range(0, 6));
      mask_all_i     = ($urandom_range(0, 5) == 0);
      base_thr_i     = 8'($urandom_range(0, 6));
      svc_prio_i     = 8'($urandom_range(0, 7));
      fault_active_i = ($urandom_range(0, 7) == 0);
      route_ns_i     = 1'($urandom_range(0, 1));
      req_i          = 1'($urandom_range(0, 1));
      step("R3 R7 R8 R9 random");
    end
    req_i = 1'b0;
    step("R8 final idle");

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule